// File: doc/BRIEF.md
# Framebuffer Write Mode Engine

This block turns one processor store into a run of single-byte writes to a frame buffer that holds one byte per pixel. A 16-bit mode word, taken from the top half of the destination access-mode register, selects how the store is used. Two families exist. In the byte-lane family, four data bytes go to four consecutive pixels. In the expansion family, each data bit becomes one pixel, which receives either a colour or a fixed 1/0 value. A bitmask and an image-operation word gate the individual pixels, and pixels that land past the end of the buffer are dropped. Raster-operation combining and frame-buffer reads are handled elsewhere. The byte port performs a plain store.

A store enters through a valid/ready handshake. A transfer is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. Sideband inputs are sampled only on that edge. While a transfer is still emitting pixels, `wr_ready` stays low. A held request waits with its payload stable until `wr_ready` returns. After each accepted store the block reports the advanced write pointer, so the caller can walk across the screen. The image-operation word and the plane mask are held inside the block. Each has its own load strobe.

Top module: `fbw_engine`

## Requirements
- R1: After reset the image-operation word reads 0x23000300, the plane mask reads 0xFF, and `busy`, `pix_we`, `ptr_vld` and `mode_err` are low. `iop_we`/`pm_we` load new values on the next edge.
- R2: Modes 0xBBE0 and 0x3BA0 use `wr_pos` itself as the byte offset and write four pixels. The data is byte-reversed: `wr_data[7:0]` goes to the lowest address and `wr_data[31:24]` to offset+3. The pointer advances by 4.
- R3: Mode 0x1360 writes four pixels at offset (Y+`wr_row`)*`fb_width`+X, where X=`wr_pos[X_BITS-1:0]` and Y is the next Y_BITS bits. `wr_data[31:24]` goes to the lowest address. The pointer advances by 4.
- R4: Mode 0x13A0 is like R3, but X and Y are taken from `wr_pos` shifted right by two. The pointer advances by 16.
- R5: In the byte-lane modes, when image-operation bit 29 is set, the byte at offset+i (i=0..3) is written only if `bitmask[31-i]` is set. When bit 29 is clear, all four bytes are written.
- R6: Mode 0x2EA0 expands n=8×s data bits, with s=1 for size code 1, s=2 for code 2 and s=4 for any other code. Pixel offset+i takes `wr_data[n-1-i]`: a 1 writes `fg_color` and a 0 writes `bg_color`. The offset is computed as in R4 and the pointer advances by 4.
- R7: Mode 0x28A0 behaves as R6, but writes the value 1 for a set bit and 0 for a clear bit.
- R8: In the expansion modes, pixel i needs `bitmask[31-i]` set when image-operation bit 29 is set. When image-operation bit 28 or bit 1 is set, pixels whose data bit is 0 are not written.
- R9: No pixel is written at an address of BUF_SIZE or above. The other pixels of the same transfer are still written.
- R10: After acceptance, the block produces one candidate pixel per cycle at consecutive addresses, starting the cycle after the accepting edge. `busy` is high for exactly 4 cycles (byte-lane modes) or n cycles (expansion modes).
- R11: `wr_ready` equals not `busy` outside reset. A request held while `busy` is high is accepted only after `busy` falls.
- R12: A mode word outside the six listed values writes no pixel and leaves `busy` low. `mode_err` is high for the one cycle after acceptance, and the returned pointer equals `wr_pos`.
- R13: `ptr_vld` is high for the one cycle after every acceptance, and `ptr_out` then holds the advanced pointer (modulo 2^POS_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Engine can accept a store |
| wr_pos | input | POS_W | Write position / pointer |
| wr_row | input | ROW_W | Character-row counter added to Y |
| wr_size | input | 3 | Store size in bytes (1, 2, else 4) |
| wr_data | input | 32 | Store data |
| dst_mode | input | 16 | Mode word (upper half of destination access register) |
| bitmask | input | 32 | Per-pixel / per-byte write mask |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| fb_width | input | WID_W | Frame width in pixels |
| iop_we | input | 1 | Load image-operation word |
| iop_wdata | input | 32 | New image-operation word |
| pm_we | input | 1 | Load plane mask |
| pm_wdata | input | 8 | New plane mask |
| iop_q | output | 32 | Current image-operation word |
| pmask_q | output | 8 | Current plane mask |
| busy | output | 1 | Pixel run in progress |
| pix_we | output | 1 | Byte write strobe |
| pix_addr | output | OFF_W | Byte write address |
| pix_data | output | 8 | Byte write value |
| ptr_vld | output | 1 | Updated pointer valid |
| ptr_out | output | POS_W | Updated pointer |
| mode_err | output | 1 | Unknown mode word seen |

## Verification
The embedded properties check the timing rules on every cycle. An acceptance of a known mode raises `busy`, and no acceptance happens while `busy` is high. Candidate addresses step by one within a run. `mode_err` and `ptr_vld` follow only from an acceptance, and an error never coincides with a pixel run. The data placement can only be shown by the bench sweep, which compares every emitted address and value with an arithmetic model. That covers byte reversal, MSB-first expansion, mask gating by bit 29, transparency, the buffer-end cutoff and the pointer increments, across all modes, sizes and image-operation patterns.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [2:0] {
    FM_NONE,
    FM_SWAP,
    FM_LIN,
    FM_QUAD,
    FM_EXPC,
    FM_EXPB
  } fmode_e;

  localparam logic [31:0] IOP_RESET = 32'h2300_0300;
  localparam logic [7:0]  PM_RESET  = 8'hFF;
  localparam int          IOP_GATE_BIT = 29;

  function automatic fmode_e fm_decode(input logic [15:0] m);
    case (m)
      16'h3BA0, 16'hBBE0: return FM_SWAP;
      16'h1360:           return FM_LIN;
      16'h13A0:           return FM_QUAD;
      16'h2EA0:           return FM_EXPC;
      16'h28A0:           return FM_EXPB;
      default:            return FM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fbw_addr.sv
module fbw_addr
  import fbw_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int X_BITS = 6,
  parameter int Y_BITS = 5,
  parameter int ROW_W  = 4,
  parameter int WID_W  = 8,
  parameter int OFF_W  = 20
) (
  input  fmode_e             fmode,
  input  logic [POS_W-1:0]   pos,
  input  logic [ROW_W-1:0]   row,
  input  logic [WID_W-1:0]   width,
  output logic [OFF_W-1:0]   off
);
  logic             quarter;
  logic [OFF_W-1:0] xv, yv;

  always_comb begin
    quarter = (fmode == FM_QUAD) || (fmode == FM_EXPC) || (fmode == FM_EXPB);
    if (quarter) begin
      xv = OFF_W'(pos[2 +: X_BITS]);
      yv = OFF_W'(pos[2 + X_BITS +: Y_BITS]) + OFF_W'(row);
    end else begin
      xv = OFF_W'(pos[0 +: X_BITS]);
      yv = OFF_W'(pos[X_BITS +: Y_BITS]) + OFF_W'(row);
    end
    if (fmode == FM_SWAP) off = OFF_W'(pos);
    else                  off = yv * OFF_W'(width) + xv;
  end
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq #(
  parameter int OFF_W    = 20,
  parameter int BUF_SIZE = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             expand,
  input  logic [5:0]       n_pix,
  input  logic [OFF_W-1:0] base,
  input  logic [31:0]      data_in,
  input  logic [31:0]      mask_in,
  input  logic [7:0]       fgv,
  input  logic [7:0]       bgv,
  input  logic             mask_en,
  input  logic             transp,
  output logic             busy,
  output logic             pix_we,
  output logic [OFF_W-1:0] pix_addr,
  output logic [7:0]       pix_data
);
  localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(BUF_SIZE);

  logic             busy_q, exp_q, men_q, tr_q;
  logic [5:0]       idx_q, cnt_q;
  logic [OFF_W-1:0] base_q;
  logic [31:0]      dat_q, msk_q;
  logic [7:0]       fg_q, bg_q;
  logic             last;
  logic [OFF_W:0]   sum;
  logic             allow, keep;

  assign last = (idx_q == cnt_q - 6'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; exp_q <= 1'b0; men_q <= 1'b0; tr_q <= 1'b0;
      idx_q  <= '0;   cnt_q <= '0;   base_q <= '0;
      dat_q  <= '0;   msk_q <= '0;   fg_q <= '0; bg_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;  idx_q <= '0;     cnt_q <= n_pix;
      exp_q  <= expand; base_q <= base; dat_q <= data_in;
      msk_q  <= mask_in; fg_q <= fgv;   bg_q <= bgv;
      men_q  <= mask_en; tr_q <= transp;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 6'd1;
        dat_q <= exp_q ? {dat_q[30:0], 1'b0} : {dat_q[23:0], 8'h00};
        msk_q <= {msk_q[30:0], 1'b0};
      end
    end
  end

  always_comb begin
    sum      = {1'b0, base_q} + (OFF_W+1)'(idx_q);
    allow    = !men_q || msk_q[31];
    keep     = !exp_q || dat_q[31] || !tr_q;
    pix_we   = busy_q && (sum < LIMIT) && allow && keep;
    pix_addr = sum[OFF_W-1:0];
    pix_data = exp_q ? (dat_q[31] ? fg_q : bg_q) : dat_q[31:24];
  end

  assign busy = busy_q;

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);
  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (pix_addr == OFF_W'($past(pix_addr) + 1'b1)));
  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !start);
endmodule

// File: rtl/fbw_engine.sv
module fbw_engine
  import fbw_pkg::*;
#(
  parameter int POS_W    = 16,
  parameter int X_BITS   = 6,
  parameter int Y_BITS   = 5,
  parameter int ROW_W    = 4,
  parameter int WID_W    = 8,
  parameter int OFF_W    = 20,
  parameter int BUF_SIZE = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [POS_W-1:0] wr_pos,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [2:0]       wr_size,
  input  logic [31:0]      wr_data,
  input  logic [15:0]      dst_mode,
  input  logic [31:0]      bitmask,
  input  logic [7:0]       fg_color,
  input  logic [7:0]       bg_color,
  input  logic [WID_W-1:0] fb_width,
  input  logic             iop_we,
  input  logic [31:0]      iop_wdata,
  input  logic             pm_we,
  input  logic [7:0]       pm_wdata,
  output logic [31:0]      iop_q,
  output logic [7:0]       pmask_q,
  output logic             busy,
  output logic             pix_we,
  output logic [OFF_W-1:0] pix_addr,
  output logic [7:0]       pix_data,
  output logic             ptr_vld,
  output logic [POS_W-1:0] ptr_out,
  output logic             mode_err
);
  fmode_e           fm;
  logic             acc, expand, known;
  logic [5:0]       n_pix;
  logic [31:0]      data_al;
  logic [OFF_W-1:0] base;
  logic [POS_W-1:0] incr;
  logic [7:0]       fgv, bgv;

  assign wr_ready = !busy && !rst;
  assign acc      = wr_valid && wr_ready;

  always_comb begin
    fm     = fm_decode(dst_mode);
    known  = (fm != FM_NONE);
    expand = (fm == FM_EXPC) || (fm == FM_EXPB);
    if (expand) begin
      case (wr_size)
        3'd1:    n_pix = 6'd8;
        3'd2:    n_pix = 6'd16;
        default: n_pix = 6'd32;
      endcase
    end else begin
      n_pix = 6'd4;
    end
    if (fm == FM_SWAP)
      data_al = {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
    else if (expand)
      data_al = wr_data << (6'd32 - n_pix);
    else
      data_al = wr_data;
    fgv = (fm == FM_EXPB) ? 8'd1 : fg_color;
    bgv = (fm == FM_EXPB) ? 8'd0 : bg_color;
    case (fm)
      FM_NONE: incr = '0;
      FM_QUAD: incr = POS_W'(16);
      default: incr = POS_W'(4);
    endcase
  end

  fbw_addr #(
    .POS_W(POS_W), .X_BITS(X_BITS), .Y_BITS(Y_BITS),
    .ROW_W(ROW_W), .WID_W(WID_W), .OFF_W(OFF_W)
  ) u_addr (
    .fmode(fm), .pos(wr_pos), .row(wr_row), .width(fb_width), .off(base)
  );

  fbw_seq #(.OFF_W(OFF_W), .BUF_SIZE(BUF_SIZE)) u_seq (
    .clk(clk), .rst(rst), .start(acc && known), .expand(expand),
    .n_pix(n_pix), .base(base), .data_in(data_al), .mask_in(bitmask),
    .fgv(fgv), .bgv(bgv), .mask_en(iop_q[IOP_GATE_BIT]),
    .transp(iop_q[28] || iop_q[1]),
    .busy(busy), .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iop_q    <= IOP_RESET;
      pmask_q  <= PM_RESET;
      ptr_vld  <= 1'b0;
      ptr_out  <= '0;
      mode_err <= 1'b0;
    end else begin
      if (iop_we) iop_q   <= iop_wdata;
      if (pm_we)  pmask_q <= pm_wdata;
      ptr_vld  <= acc;
      mode_err <= acc && !known;
      if (acc) ptr_out <= wr_pos + incr;
    end
  end

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> $past(acc));
  // R12
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !busy);
  // R13
  ptr_src_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_vld |-> $past(wr_valid && wr_ready));
endmodule

// File: tb/tb_fbw_engine.sv
module tb_fbw_engine;
  localparam int XB = 4, YB = 3, BUF = 200, OW = 20, PW = 16, FW = 16;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic wr_valid = 0, wr_ready;
  logic [PW-1:0] wr_pos = 0;
  logic [3:0] wr_row = 0;
  logic [2:0] wr_size = 4;
  logic [31:0] wr_data = 0, bitmask = 0, iop_wdata = 0, iop_q;
  logic [15:0] dst_mode = 0;
  logic [7:0] fg_color = 8'hA5, bg_color = 8'h3C, pm_wdata = 0, pmask_q;
  logic [7:0] fb_width = FW;
  logic iop_we = 0, pm_we = 0, busy, pix_we, ptr_vld, mode_err;
  logic [OW-1:0] pix_addr;
  logic [7:0] pix_data;
  logic [PW-1:0] ptr_out;

  fbw_engine #(.POS_W(PW), .X_BITS(XB), .Y_BITS(YB), .ROW_W(4), .WID_W(8),
               .OFF_W(OW), .BUF_SIZE(BUF)) dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  int obs_n, busy_n;
  int obs_a [0:63];
  int obs_d [0:63];
  int exp_n;
  int exp_a [0:63];
  int exp_d [0:63];

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (pix_we && obs_n < 64) begin
      obs_a[obs_n] = int'(pix_addr);
      obs_d[obs_n] = int'(pix_data);
      obs_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic set_iop(input logic [31:0] v);
    @(negedge clk); iop_we = 1; iop_wdata = v;
    @(negedge clk); iop_we = 0;
  endtask

  task automatic run(input logic [15:0] m, input int sz, input logic [31:0] d,
                     input logic [31:0] bm, input int pos, input int row);
    bit sw, ln, qd, ec, eb, ex, kn, bit_v, tr;
    int p, xx, yy, off, n, a, incr, eptr;
    logic [31:0] dd;
    string tag;
    sw = (m == 16'h3BA0) || (m == 16'hBBE0);
    ln = (m == 16'h1360); qd = (m == 16'h13A0);
    ec = (m == 16'h2EA0); eb = (m == 16'h28A0);
    ex = ec || eb; kn = sw || ln || qd || ex;
    tag = sw ? "R2" : ln ? "R3" : qd ? "R4" : ec ? "R6" : eb ? "R7" : "R12";
    tr = iop_q[28] || iop_q[1];
    p = (qd || ex) ? (pos >> 2) : pos;
    xx = p & ((1 << XB) - 1);
    yy = (p >> XB) & ((1 << YB) - 1);
    off = sw ? pos : (yy + row) * FW + xx;
    n = ex ? ((sz == 1) ? 8 : (sz == 2) ? 16 : 32) : (kn ? 4 : 0);
    exp_n = 0;
    dd = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    for (int i = 0; i < n; i++) begin
      a = off + i;
      if (a < BUF && (!iop_q[29] || bm[31-i])) begin
        if (!ex) begin
          exp_a[exp_n] = a; exp_d[exp_n] = int'(dd[31-8*i -: 8]); exp_n++;
        end else begin
          bit_v = d[n-1-i];
          if (bit_v || !tr) begin
            exp_a[exp_n] = a;
            exp_d[exp_n] = eb ? int'(bit_v) : int'(bit_v ? fg_color : bg_color);
            exp_n++;
          end
        end
      end
    end
    incr = qd ? 16 : (kn ? 4 : 0);
    eptr = (pos + incr) & 16'hFFFF;
    @(negedge clk);
    obs_n = 0; busy_n = 0;
    dst_mode = m; wr_size = 3'(sz); wr_data = d; bitmask = bm;
    wr_pos = PW'(pos); wr_row = 4'(row); wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    // R13 pointer returned one cycle after acceptance
    chk(ptr_vld && ptr_out == PW'(eptr), "R13", int'(ptr_out), eptr);
    // R12 error flag only for unknown modes
    chk(mode_err == !kn, "R12", int'(mode_err), int'(!kn));
    while (busy) @(negedge clk);
    @(negedge clk);
    // R10 busy length equals pixel count
    chk(busy_n == n, "R10", busy_n, n);
    chk(obs_n == exp_n, tag, obs_n, exp_n);
    if (obs_n == exp_n)
      for (int i = 0; i < exp_n; i++)
        chk(obs_a[i] == exp_a[i] && obs_d[i] == exp_d[i],
            (iop_q[29] ? "R5/R8" : (exp_a[i] >= BUF - 4 ? "R9" : tag)),
            obs_a[i] * 256 + obs_d[i], exp_a[i] * 256 + exp_d[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] modes [0:6];
    logic [31:0] iops  [0:4];
    logic [31:0] dats  [0:3];
    logic [31:0] bms   [0:3];
    int poss [0:2];
    modes = '{16'h3BA0, 16'hBBE0, 16'h1360, 16'h13A0, 16'h2EA0, 16'h28A0, 16'h1234};
    iops  = '{32'h2300_0300, 32'h0000_0000, 32'h1000_0000, 32'h0000_0002, 32'h3000_0000};
    dats  = '{32'h1234_5678, 32'hF0C3_A55A, 32'h0000_0001, 32'h8000_FFFF};
    bms   = '{32'hFFFF_FFFF, 32'hA5C3_0F69, 32'h5000_00FF, 32'h0000_0000};
    poss  = '{37, 188, 3166};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(iop_q == 32'h2300_0300, "R1", int'(iop_q), 32'h2300_0300);
    chk(pmask_q == 8'hFF, "R1", int'(pmask_q), 255);
    chk(!busy && !pix_we && !ptr_vld && !mode_err, "R1", int'(busy), 0);
    chk(wr_ready, "R11", int'(wr_ready), 1);
    @(negedge clk); pm_we = 1; pm_wdata = 8'h3E;
    @(negedge clk); pm_we = 0;
    chk(pmask_q == 8'h3E, "R1", int'(pmask_q), 8'h3E);

    for (int ii = 0; ii < 5; ii++) begin
      set_iop(iops[ii]);
      for (int mi = 0; mi < 7; mi++)
        for (int sz = 1; sz <= 4; sz++)
          if (sz != 3)
            for (int di = 0; di < 4; di++)
              for (int pi = 0; pi < 3; pi++)
                for (int r = 0; r < 9; r += 8)
                  run(modes[mi], sz, dats[di], bms[(di + ii) % 4], poss[pi], r);
    end

    // R11 back-pressure: request held during a run waits for busy to fall
    set_iop(32'h0);
    @(negedge clk);
    dst_mode = 16'h2EA0; wr_size = 3'd4; wr_pos = 16'd0; wr_row = 0; wr_valid = 1;
    @(negedge clk);
    dst_mode = 16'h1360; wr_pos = 16'd100;
    chk(busy && !wr_ready, "R11", int'(wr_ready), 0);
    repeat (5) @(negedge clk);
    chk(!ptr_vld, "R11", int'(ptr_vld), 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    chk(ptr_vld && ptr_out == 16'd104, "R11", int'(ptr_out), 104);
    repeat (8) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule